// File: doc/BRIEF.md
# LED Blink and Heartbeat Sequencer

This block steps one LED channel through a timed lighting pattern. It does not drive any current. It raises and lowers a request, `led_on`, that an external fade engine follows. It also drives a level select, `hb_sel`, that tells the current generator whether the pulse in progress uses the normal level or the heartbeat level. The fade engine answers each rising request with `fade_in_done` and each falling request with `fade_out_done`. Every timed phase waits for the matching handshake before its count begins.

When the channel is enabled, a start delay runs first. After that the channel repeats a pulse followed by a dark gap. The pulse length is the on time, which all channels share. The gap length comes from the channel's own off time. Two off-time codes are reserved. One keeps the channel lit for good after its first fade-in. The other lets the channel run a single cycle and then stay dark until the enable goes low and then high again. With heartbeat enabled, each cycle holds two pulses. The first uses the normal level, on time and off time. The second uses the heartbeat level, heartbeat on time and heartbeat off time. Time bases of 10 ms and 100 ms arrive as single-cycle strobes from outside.

Top module: `blink_hb_seq`

## Requirements
- R1: After synchronous reset, `led_on` and `hb_sel` are both 0.
- R2: While `chan_en` is high, the sequencer first counts `start_dly` 10 ms strobes and then raises `led_on`. A code of 0 raises `led_on` two clocks after the enable is seen.
- R3: The on-time count starts only after `fade_in_done` arrives while `led_on` is high. Strobes that arrive earlier are not counted. `led_on` drops after the on time, counted in 10 ms strobes.
- R4: The off-time count starts only after `fade_out_done` arrives while `led_on` is low. For codes 0 to 0x7D, `led_on` rises again after code × 100 ms strobes.
- R5: Off-time code 0x7F turns blinking off. After the first `fade_in_done`, `led_on` stays high for as long as `chan_en` is high, whatever strobes arrive.
- R6: Off-time code 0x7E ends the channel after one cycle. After the last fade-out of that cycle, `led_on` stays low until `chan_en` goes low and then high again. The restart then begins with the start delay.
- R7: With `hb_en` high, pulses alternate between two kinds. The first pulse uses `on_time` and `off_time`, with `hb_sel` = 0. The second uses `hb_on_time` and `hb_off_time`, with `hb_sel` = 1. The pattern then repeats from the first pulse.
- R8: `hb_sel` is 1 through the rise, hold and fade-out of the heartbeat pulse. It returns to 0 when `fade_out_done` ends that pulse.
- R9: When `chan_en` is low, the sequencer goes back to idle. `led_on` drops one clock later, and any delay or pulse in progress is abandoned. The next enable starts with the full start delay.
- R10: On-time codes above 75 count as 75 strobes of 10 ms (750 ms).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_10ms | input | 1 | One-cycle strobe every 10 ms |
| tick_100ms | input | 1 | One-cycle strobe every 100 ms |
| chan_en | input | 1 | Channel enable |
| start_dly | input | 7 | Start delay, in 10 ms units |
| on_time | input | 7 | Shared on time, in 10 ms units (saturates at 75) |
| off_time | input | 7 | Off time in 100 ms units; 0x7F = steady, 0x7E = single cycle |
| hb_en | input | 1 | Heartbeat pattern enable |
| hb_on_time | input | 7 | Heartbeat pulse on time, in 10 ms units (saturates at 75) |
| hb_off_time | input | 7 | Heartbeat gap, in 100 ms units (saturates at 125) |
| fade_in_done | input | 1 | Fade engine has reached the on level |
| fade_out_done | input | 1 | Fade engine has reached zero |
| led_on | output | 1 | Current-on request to the fade engine |
| hb_sel | output | 1 | 1 selects the heartbeat current level |

## Verification
The bench runs a plain blink with start delay, a delay that is cancelled and restarted, a saturated on-time code, each of the two reserved off-time codes, and a heartbeat pair. Strobes are sent while a handshake is still pending. Checking that nothing moves then shows the difference between a count that is gated by the handshake and one that runs free. Counting strobes one short of and exactly at each programmed length shows whether each phase length and its saturation are exact. A scoreboard follows every change of the (`led_on`, `hb_sel`) pair, so the order of the normal and heartbeat pulses is checked as well as their timing.

// File: rtl/blink_seq_pkg.sv
package blink_seq_pkg;

    localparam int CODE_W  = 7;
    localparam int ON_MAX  = 75;
    localparam int OFF_MAX = 125;

    localparam logic [CODE_W-1:0] OFF_STEADY  = 7'h7F;
    localparam logic [CODE_W-1:0] OFF_ONESHOT = 7'h7E;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_RISE,
        ST_ON,
        ST_FALL,
        ST_OFF,
        ST_STEADY,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              load;
        logic              slow;
        logic [CODE_W-1:0] value;
    } timer_cmd_t;

    function automatic logic [CODE_W-1:0] on_ticks(input logic [CODE_W-1:0] code);
        return (int'(code) > ON_MAX) ? CODE_W'(ON_MAX) : code;
    endfunction

    function automatic logic [CODE_W-1:0] off_ticks(input logic [CODE_W-1:0] code);
        return (int'(code) > OFF_MAX) ? CODE_W'(OFF_MAX) : code;
    endfunction

endpackage

// File: rtl/blink_tick_timer.sv
module blink_tick_timer
    import blink_seq_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_fast,
    input  logic         tick_slow,
    input  logic         load,
    input  logic         load_slow,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;
    logic         use_slow;
    logic         tick;

    assign tick    = use_slow ? tick_slow : tick_fast;
    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            use_slow <= 1'b0;
        end else if (load) begin
            cnt      <= load_val;
            use_slow <= load_slow;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    // R4: an expired count stays at zero until reloaded
    a_r4_hold_at_zero: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));

    // R2: without a reload the count only ever steps down by one
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/blink_seq_fsm.sv
module blink_seq_fsm
    import blink_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic [CODE_W-1:0] start_dly,
    input  logic [CODE_W-1:0] on_time,
    input  logic [CODE_W-1:0] off_time,
    input  logic              hb_en,
    input  logic [CODE_W-1:0] hb_on_time,
    input  logic [CODE_W-1:0] hb_off_time,
    input  logic              fade_in_done,
    input  logic              fade_out_done,
    input  logic              tmr_expired,
    output timer_cmd_t        tmr_cmd,
    output logic              led_on,
    output logic              hb_sel
);
    seq_state_e st, st_nxt;
    logic       hb_phase, hb_phase_nxt;
    logic       cycle_last;

    assign cycle_last = !hb_en || hb_phase;

    always_comb begin
        st_nxt       = st;
        hb_phase_nxt = hb_phase;
        tmr_cmd      = '{load: 1'b0, slow: 1'b0, value: '0};
        if (!chan_en) begin
            st_nxt       = ST_IDLE;
            hb_phase_nxt = 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    st_nxt       = ST_DELAY;
                    hb_phase_nxt = 1'b0;
                    tmr_cmd      = '{load: 1'b1, slow: 1'b0, value: start_dly};
                end
                ST_DELAY: if (tmr_expired) st_nxt = ST_RISE;
                ST_RISE: begin
                    if (fade_in_done) begin
                        if (!hb_phase && off_time == OFF_STEADY) begin
                            st_nxt = ST_STEADY;
                        end else begin
                            st_nxt  = ST_ON;
                            tmr_cmd = '{load: 1'b1, slow: 1'b0,
                                        value: hb_phase ? on_ticks(hb_on_time)
                                                        : on_ticks(on_time)};
                        end
                    end
                end
                ST_ON: if (tmr_expired) st_nxt = ST_FALL;
                ST_FALL: begin
                    if (fade_out_done) begin
                        if (cycle_last && off_time == OFF_ONESHOT) begin
                            st_nxt = ST_DONE;
                        end else begin
                            st_nxt       = ST_OFF;
                            hb_phase_nxt = hb_en && !hb_phase;
                            tmr_cmd      = '{load: 1'b1, slow: 1'b1,
                                             value: hb_phase ? off_ticks(hb_off_time)
                                                             : off_ticks(off_time)};
                        end
                    end
                end
                ST_OFF: if (tmr_expired) st_nxt = ST_RISE;
                ST_STEADY: st_nxt = ST_STEADY;
                ST_DONE:   st_nxt = ST_DONE;
                default:   st_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            hb_phase <= 1'b0;
        end else begin
            st       <= st_nxt;
            hb_phase <= hb_phase_nxt;
        end
    end

    always_comb begin
        led_on = (st == ST_RISE) || (st == ST_ON) || (st == ST_STEADY);
        hb_sel = hb_phase && ((st == ST_RISE) || (st == ST_ON) || (st == ST_FALL));
    end

    // R9: a low enable always returns the sequencer to idle
    a_r9_disable_idles: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (st == ST_IDLE && !hb_phase));

    // R3: the pulse holds at the rise step until the fade engine answers
    a_r3_rise_waits: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RISE && !fade_in_done && chan_en) |=> (st == ST_RISE));

    // R4: the gap does not start before the fade-out is reported
    a_r4_fall_waits: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FALL && !fade_out_done && chan_en) |=> (st == ST_FALL));

    // R5: steady lighting persists while enabled
    a_r5_steady_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STEADY && chan_en) |=> (st == ST_STEADY && led_on));

    // R6: a finished single cycle stays dark while enabled
    a_r6_done_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && chan_en) |=> (st == ST_DONE && !led_on));

endmodule

// File: rtl/blink_hb_seq.sv
module blink_hb_seq
    import blink_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_10ms,
    input  logic              tick_100ms,
    input  logic              chan_en,
    input  logic [CODE_W-1:0] start_dly,
    input  logic [CODE_W-1:0] on_time,
    input  logic [CODE_W-1:0] off_time,
    input  logic              hb_en,
    input  logic [CODE_W-1:0] hb_on_time,
    input  logic [CODE_W-1:0] hb_off_time,
    input  logic              fade_in_done,
    input  logic              fade_out_done,
    output logic              led_on,
    output logic              hb_sel
);
    timer_cmd_t tmr_cmd;
    logic       tmr_expired;

    blink_seq_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .chan_en       (chan_en),
        .start_dly     (start_dly),
        .on_time       (on_time),
        .off_time      (off_time),
        .hb_en         (hb_en),
        .hb_on_time    (hb_on_time),
        .hb_off_time   (hb_off_time),
        .fade_in_done  (fade_in_done),
        .fade_out_done (fade_out_done),
        .tmr_expired   (tmr_expired),
        .tmr_cmd       (tmr_cmd),
        .led_on        (led_on),
        .hb_sel        (hb_sel)
    );

    blink_tick_timer #(.W(CODE_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_fast (tick_10ms),
        .tick_slow (tick_100ms),
        .load      (tmr_cmd.load),
        .load_slow (tmr_cmd.slow),
        .load_val  (tmr_cmd.value),
        .expired   (tmr_expired)
    );

    // R8: the heartbeat level is never selected for a channel that is off
    a_r8_sel_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !hb_sel);

endmodule

// File: tb/blink_hb_seq_test.sv
module blink_hb_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_10ms = 1'b0, tick_100ms = 1'b0;
    logic       chan_en = 1'b0, hb_en = 1'b0;
    logic [6:0] start_dly = '0, on_time = '0, off_time = '0;
    logic [6:0] hb_on_time = '0, hb_off_time = '0;
    logic       fade_in_done = 1'b0, fade_out_done = 1'b0;
    logic       led_on, hb_sel;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] exp_q[$];
    logic [1:0] prev_out;
    bit         mon_on = 1'b0;

    always #10 clk = ~clk;

    blink_hb_seq uut (
        .clk(clk), .rst(rst), .tick_10ms(tick_10ms), .tick_100ms(tick_100ms),
        .chan_en(chan_en), .start_dly(start_dly), .on_time(on_time),
        .off_time(off_time), .hb_en(hb_en), .hb_on_time(hb_on_time),
        .hb_off_time(hb_off_time), .fade_in_done(fade_in_done),
        .fade_out_done(fade_out_done), .led_on(led_on), .hb_sel(hb_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic l, input logic h);
        chk({led_on, hb_sel} == {l, h}, req, int'({led_on, hb_sel}), int'({l, h}));
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t10(input int n);
        repeat (n) begin
            @(negedge clk) tick_10ms = 1'b1;
            @(negedge clk) tick_10ms = 1'b0;
        end
    endtask

    task automatic t100(input int n);
        repeat (n) begin
            @(negedge clk) tick_100ms = 1'b1;
            @(negedge clk) tick_100ms = 1'b0;
        end
    endtask

    task automatic fin();
        @(negedge clk) fade_in_done = 1'b1;
        @(negedge clk) fade_in_done = 1'b0;
    endtask

    task automatic fout();
        @(negedge clk) fade_out_done = 1'b1;
        @(negedge clk) fade_out_done = 1'b0;
    endtask

    task automatic expect_change(input logic l, input logic h);
        exp_q.push_back({l, h});
    endtask

    // monitor: every output change must match the next expected item
    always @(posedge clk) begin
        #2;
        if (mon_on && {led_on, hb_sel} != prev_out) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 scoreboard unexpected change", int'({led_on, hb_sel}), int'(prev_out));
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk({led_on, hb_sel} == e, "R7 scoreboard order", int'({led_on, hb_sel}), int'(e));
            end
        end
        prev_out = {led_on, hb_sel};
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk_out("R1 reset outputs", 1'b0, 1'b0);
        prev_out = {led_on, hb_sel};
        mon_on = 1'b1;

        // R2/R3/R4 plain blink
        start_dly = 7'd4; on_time = 7'd3; off_time = 7'd2;
        chan_en = 1'b1;
        cyc(2);
        chk_out("R2 dark at delay start", 1'b0, 1'b0);
        t10(3); cyc(1);
        chk_out("R2 dark one strobe early", 1'b0, 1'b0);
        expect_change(1'b1, 1'b0);
        t10(1); cyc(2);
        chk_out("R2 rises after delay", 1'b1, 1'b0);
        t10(5); cyc(1);
        chk_out("R3 strobes ignored before fade-in", 1'b1, 1'b0);
        fin();
        t10(2); cyc(1);
        chk_out("R3 still on one strobe early", 1'b1, 1'b0);
        expect_change(1'b0, 1'b0);
        t10(1); cyc(2);
        chk_out("R3 falls after on time", 1'b0, 1'b0);
        t100(3); cyc(1);
        chk_out("R4 gap waits for fade-out", 1'b0, 1'b0);
        fout();
        t100(1); cyc(1);
        chk_out("R4 dark one strobe early", 1'b0, 1'b0);
        expect_change(1'b1, 1'b0);
        t100(1); cyc(2);
        chk_out("R4 rises after off time", 1'b1, 1'b0);
        expect_change(1'b0, 1'b0);
        chan_en = 1'b0; cyc(2);
        chk_out("R9 disable drops request", 1'b0, 1'b0);

        // R9 cancelled delay restarts in full
        start_dly = 7'd5;
        chan_en = 1'b1; cyc(2);
        t10(3);
        chan_en = 1'b0; cyc(2);
        chan_en = 1'b1; cyc(2);
        t10(4); cyc(1);
        chk_out("R9 delay restarted in full", 1'b0, 1'b0);
        expect_change(1'b1, 1'b0);
        t10(1); cyc(2);
        chk_out("R9 rises after full delay", 1'b1, 1'b0);
        expect_change(1'b0, 1'b0);
        chan_en = 1'b0; cyc(2);

        // R10 on-time saturation
        start_dly = 7'd0; on_time = 7'd100; off_time = 7'd5;
        expect_change(1'b1, 1'b0);
        chan_en = 1'b1; cyc(3);
        chk_out("R2 zero delay rises", 1'b1, 1'b0);
        fin();
        t10(74); cyc(1);
        chk_out("R10 on at 74 strobes", 1'b1, 1'b0);
        expect_change(1'b0, 1'b0);
        t10(1); cyc(2);
        chk_out("R10 off at 75 strobes", 1'b0, 1'b0);
        chan_en = 1'b0; cyc(2);

        // R5 steady code 0x7F
        on_time = 7'd2; off_time = 7'h7F;
        expect_change(1'b1, 1'b0);
        chan_en = 1'b1; cyc(3);
        fin();
        t10(200); t100(50); fout(); cyc(1);
        chk_out("R5 steady stays on", 1'b1, 1'b0);
        expect_change(1'b0, 1'b0);
        chan_en = 1'b0; cyc(2);

        // R6 single-cycle code 0x7E
        on_time = 7'd1; off_time = 7'h7E;
        expect_change(1'b1, 1'b0);
        chan_en = 1'b1; cyc(3);
        fin();
        expect_change(1'b0, 1'b0);
        t10(1); cyc(2);
        chk_out("R6 pulse ends", 1'b0, 1'b0);
        fout(); cyc(2);
        t100(20); t10(20); fin(); cyc(1);
        chk_out("R6 stays dark after cycle", 1'b0, 1'b0);
        chan_en = 1'b0; cyc(2);
        chk_out("R6 dark while disabled", 1'b0, 1'b0);
        expect_change(1'b1, 1'b0);
        chan_en = 1'b1; cyc(3);
        chk_out("R6 re-toggle restarts", 1'b1, 1'b0);
        expect_change(1'b0, 1'b0);
        chan_en = 1'b0; cyc(2);

        // R7/R8 heartbeat pair
        hb_en = 1'b1; on_time = 7'd2; off_time = 7'd1;
        hb_on_time = 7'd3; hb_off_time = 7'd2;
        expect_change(1'b1, 1'b0);
        chan_en = 1'b1; cyc(3);
        chk_out("R7 first pulse normal level", 1'b1, 1'b0);
        fin();
        expect_change(1'b0, 1'b0);
        t10(2); cyc(2);
        fout();
        expect_change(1'b1, 1'b1);
        t100(1); cyc(2);
        chk_out("R8 second pulse heartbeat level", 1'b1, 1'b1);
        fin();
        t10(2); cyc(1);
        chk_out("R7 heartbeat on time longer", 1'b1, 1'b1);
        expect_change(1'b0, 1'b1);
        t10(1); cyc(2);
        chk_out("R8 select held during fade-out", 1'b0, 1'b1);
        expect_change(1'b0, 1'b0);
        fout(); cyc(1);
        chk_out("R8 select released after fade-out", 1'b0, 1'b0);
        t100(1); cyc(1);
        chk_out("R7 heartbeat gap one strobe early", 1'b0, 1'b0);
        expect_change(1'b1, 1'b0);
        t100(1); cyc(2);
        chk_out("R7 pattern repeats normal pulse", 1'b1, 1'b0);
        expect_change(1'b0, 1'b0);
        chan_en = 1'b0; cyc(3);

        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule